// File: doc/BRIEF.md
# Microcode Address Sequencer with Control-Store Loader

This block keeps the instruction word that the processor is currently executing and turns it into a 10-bit microcode address. The address is built from three parts. The first is the instruction's 5-bit opcode field. The second is its 2-bit function field. The third is a 3-bit step count that advances once per clock while the instruction runs. A pending exception at the first step replaces the opcode with a reserved all-ones value, so that the exception-entry microcode runs in place of the fetched instruction. The low 11 bits of the held instruction are driven out at all times for the immediate-operand logic.

At boot, a separate path loads the control store. A stream of 16-bit copy addresses arrives together with a copy-active strobe. The block turns the top three address bits into a one-hot write enable across eight microcode RAM banks. Each bank therefore receives its own 8 KB slice of the 64 KB control image.

Top module: `uop_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the held instruction, the step count and `bank_we` all clear to zero. After that edge, with `exc_pend` low, `uaddr`, `imm_bits` and `bank_we` read zero.
- R2: When `insn_ld` is high at a rising edge, the held instruction takes the value of `insn_din`. When `insn_ld` is low, the held instruction keeps its value whatever `insn_din` carries.
- R3: `imm_bits` always equals bits [10:0] of the held instruction.
- R4: When the exception override of R6 is not active, `uaddr` equals the concatenation {held[15:11], held[10:9], step}. Here held[15:11] is the opcode field, held[10:9] is the function field and step is the 3-bit step count.
- R5: The step count returns to 0 at any edge where `insn_ld` or `end_stb` is high. At every other edge it increases by one, and it wraps from 7 to 0.
- R6: When `exc_pend` is high and the step count is 0, `uaddr[9:5]` reads 5'b11111 while the function and step fields are unchanged. At any nonzero step, `exc_pend` has no effect on `uaddr`.
- R7: When `copy_act` is high at an edge, `bank_we` after that edge has exactly one bit set, namely bit `copy_addr[15:13]`.
- R8: When `copy_act` is low at an edge, `bank_we` after that edge is all zeros, whatever `copy_addr` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_ld | input | 1 | Load enable for the instruction holder |
| insn_din | input | 16 | Instruction word to load |
| end_stb | input | 1 | End-of-instruction strobe; restarts the step count |
| exc_pend | input | 1 | Exception pending; overrides the opcode at step 0 |
| copy_act | input | 1 | Control-store copy in progress |
| copy_addr | input | 16 | Byte address inside the 64 KB control image |
| imm_bits | output | 11 | Low 11 bits of the held instruction |
| uaddr | output | 10 | Microcode address |
| bank_we | output | 8 | One-hot write enables for the microcode RAM banks |

## Verification
Every one of the 128 opcode and function combinations is loaded and then walked through all eight steps and the wrap back to 0. This separates field placement errors from counter errors. The exception input is applied at step 0 and at nonzero steps, and its effect is checked with instruction words of both all-ones and mixed opcodes, which tells a correct override apart from a missing one or one that is never released. The copy path is swept over every bank selector, with several values in the low address bits to show that only the top bits steer the enable. Strobe-off cycles with live addresses confirm that no bank is enabled.

// File: rtl/uas_pkg.sv
package uas_pkg;
  localparam int unsigned DEF_INSN_W  = 16;
  localparam int unsigned DEF_OPC_W   = 5;
  localparam int unsigned DEF_FN_W    = 2;
  localparam int unsigned DEF_STEP_W  = 3;
  localparam int unsigned DEF_IMM_W   = 11;
  localparam int unsigned DEF_NBANK   = 8;
  localparam int unsigned DEF_CADDR_W = 16;
endpackage

// File: rtl/uas_insn_reg.sv
module uas_insn_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= din;
  end

  // R2
  ld_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(din));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
endmodule

// File: rtl/uas_step_ctr.sv
module uas_step_ctr #(
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst || restart) step <= '0;
    else                step <= step + 1'b1;
  end

  // R5
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> step == '0);
  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> step == STEP_W'($past(step) + 1'b1));
endmodule

// File: rtl/uas_addr_form.sv
module uas_addr_form #(
  parameter int unsigned OPC_W  = 5,
  parameter int unsigned FN_W   = 2,
  parameter int unsigned STEP_W = 3,
  localparam int unsigned UA_W  = OPC_W + FN_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opc,
  input  logic [FN_W-1:0]   fn,
  input  logic [STEP_W-1:0] step,
  input  logic              exc_pend,
  output logic [UA_W-1:0]   uaddr
);
  localparam logic [OPC_W-1:0] EXC_OPC = {OPC_W{1'b1}};

  logic             at_entry;
  logic [OPC_W-1:0] opc_eff;

  always_comb begin
    at_entry = (step == '0);
    opc_eff  = (exc_pend && at_entry) ? EXC_OPC : opc;
    uaddr    = {opc_eff, fn, step};
  end

  // R6
  exc_force_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_pend && step == '0) |-> uaddr[UA_W-1 -: OPC_W] == EXC_OPC);
  // R6
  exc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |-> uaddr[UA_W-1 -: OPC_W] == opc);
  // R4
  step_field_chk: assert property (@(posedge clk) disable iff (rst)
    uaddr[STEP_W-1:0] == step && uaddr[STEP_W +: FN_W] == fn);
endmodule

// File: rtl/uas_bank_dec.sv
module uas_bank_dec #(
  parameter int unsigned NBANK = 8,
  localparam int unsigned SEL_W = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             copy_act,
  input  logic [SEL_W-1:0] sel,
  output logic [NBANK-1:0] bank_we
);
  logic [NBANK-1:0] hit;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    assign hit[k] = copy_act && (sel == SEL_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) bank_we <= '0;
    else     bank_we <= hit;
  end

  // R7
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    copy_act |=> $countones(bank_we) == 1);
  // R7
  bank_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));
  // R8
  bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !copy_act |=> bank_we == '0);
endmodule

// File: rtl/uop_addr_seq.sv
module uop_addr_seq
  import uas_pkg::*;
#(
  parameter int unsigned INSN_W  = DEF_INSN_W,
  parameter int unsigned OPC_W   = DEF_OPC_W,
  parameter int unsigned FN_W    = DEF_FN_W,
  parameter int unsigned STEP_W  = DEF_STEP_W,
  parameter int unsigned IMM_W   = DEF_IMM_W,
  parameter int unsigned NBANK   = DEF_NBANK,
  parameter int unsigned CADDR_W = DEF_CADDR_W,
  localparam int unsigned UA_W   = OPC_W + FN_W + STEP_W,
  localparam int unsigned SEL_W  = $clog2(NBANK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_ld,
  input  logic [INSN_W-1:0]  insn_din,
  input  logic               end_stb,
  input  logic               exc_pend,
  input  logic               copy_act,
  input  logic [CADDR_W-1:0] copy_addr,
  output logic [IMM_W-1:0]   imm_bits,
  output logic [UA_W-1:0]    uaddr,
  output logic [NBANK-1:0]   bank_we
);
  localparam int unsigned FN_LSB = IMM_W - FN_W;

  logic [INSN_W-1:0] insn_q;
  logic [STEP_W-1:0] step;
  logic              unused_copy_low;

  assign unused_copy_low = ^copy_addr[CADDR_W-SEL_W-1:0];

  uas_insn_reg #(.W(INSN_W)) u_insn (
    .clk (clk),
    .rst (rst),
    .ld  (insn_ld),
    .din (insn_din),
    .q   (insn_q)
  );

  uas_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk     (clk),
    .rst     (rst),
    .restart (insn_ld | end_stb),
    .step    (step)
  );

  uas_addr_form #(.OPC_W(OPC_W), .FN_W(FN_W), .STEP_W(STEP_W)) u_form (
    .clk      (clk),
    .rst      (rst),
    .opc      (insn_q[INSN_W-1 -: OPC_W]),
    .fn       (insn_q[FN_LSB +: FN_W]),
    .step     (step),
    .exc_pend (exc_pend),
    .uaddr    (uaddr)
  );

  uas_bank_dec #(.NBANK(NBANK)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .copy_act (copy_act),
    .sel      (copy_addr[CADDR_W-1 -: SEL_W]),
    .bank_we  (bank_we)
  );

  assign imm_bits = insn_q[IMM_W-1:0];

  // R3
  imm_follow_chk: assert property (@(posedge clk) disable iff (rst)
    insn_ld |=> imm_bits == $past(insn_din[IMM_W-1:0]));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bank_we == '0 && imm_bits == '0));
endmodule

// File: tb/test_uop_addr_seq.sv
`timescale 1ns/1ps
module test_uop_addr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_ld;
  logic [15:0] insn_din;
  logic        end_stb;
  logic        exc_pend;
  logic        copy_act;
  logic [15:0] copy_addr;
  logic [10:0] imm_bits;
  logic [9:0]  uaddr;
  logic [7:0]  bank_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uop_addr_seq i_uop_addr_seq (
    .clk(clk), .rst(rst), .insn_ld(insn_ld), .insn_din(insn_din),
    .end_stb(end_stb), .exc_pend(exc_pend), .copy_act(copy_act),
    .copy_addr(copy_addr), .imm_bits(imm_bits), .uaddr(uaddr),
    .bank_we(bank_we)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] exp_ua(logic [15:0] w, int s);
    return {w[15:11], w[10:9], 3'(s)};
  endfunction

  task automatic load(logic [15:0] w);
    insn_din = w; insn_ld = 1'b1;
    tick();
    insn_ld = 1'b0;
  endtask

  initial begin
    rst = 1'b1; insn_ld = 1'b0; insn_din = 16'hFFFF; end_stb = 1'b0;
    exc_pend = 1'b0; copy_act = 1'b1; copy_addr = 16'hE000;
    tick(); tick();
    // R1 reset state
    chk("R1 uaddr", 16'(uaddr), 16'h0);
    chk("R1 imm_bits", 16'(imm_bits), 16'h0);
    chk("R1 bank_we", 16'(bank_we), 16'h0);
    rst = 1'b0; copy_act = 1'b0;

    // R4 R5 sweep all opcode/function codes through every step
    for (int c = 0; c < 128; c++) begin
      logic [15:0] w;
      w = {7'(c), 9'((c * 37 + 5) & 9'h1FF)};
      load(w);
      chk("R3 imm_bits", 16'(imm_bits), 16'(w[10:0]));
      for (int s = 0; s < 8; s++) begin
        chk("R4 uaddr step", 16'(uaddr), 16'(exp_ua(w, s)));
        tick();
      end
      chk("R5 wrap", 16'(uaddr), 16'(exp_ua(w, 0)));
    end

    // R2 hold when load is low
    load(16'hA5C3);
    insn_din = 16'h5A3C;
    tick(); tick();
    chk("R2 hold imm", 16'(imm_bits), 16'h05C3);
    chk("R2 hold uaddr", 16'(uaddr), 16'(exp_ua(16'hA5C3, 2)));

    // R5 end strobe restarts, then counting resumes
    tick();
    end_stb = 1'b1; tick(); end_stb = 1'b0;
    chk("R5 end_stb clear", 16'(uaddr), 16'(exp_ua(16'hA5C3, 0)));
    tick();
    chk("R5 after clear", 16'(uaddr), 16'(exp_ua(16'hA5C3, 1)));
    // R5 load mid-instruction clears step
    tick(); tick();
    load(16'h3E01);
    chk("R5 load clear", 16'(uaddr), 16'(exp_ua(16'h3E01, 0)));

    // R6 exception override at step 0 only
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = (k == 3) ? 16'hFFFF : 16'(16'h1234 * (k + 1));
      load(w);
      exc_pend = 1'b1;
      #1;
      chk("R6 forced", 16'(uaddr), 16'({5'h1F, w[10:9], 3'd0}));
      tick();
      chk("R6 ignored step1", 16'(uaddr), 16'(exp_ua(w, 1)));
      exc_pend = 1'b0;
      #1;
      chk("R6 release", 16'(uaddr), 16'(exp_ua(w, 1)));
    end

    // R7 bank decode sweep
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < 3; l++) begin
        copy_act = 1'b1;
        copy_addr = {3'(b), 13'((l * 13'h0AB5) ^ (b * 7))};
        tick();
        chk("R7 bank_we", 16'(bank_we), 16'(8'(1) << b));
      end
    end
    // R8 strobe low
    for (int b = 0; b < 8; b++) begin
      copy_act = 1'b0;
      copy_addr = {3'(b), 13'h1FFF};
      tick();
      chk("R8 idle", 16'(bank_we), 16'h0);
    end
    // R1 reset again clears
    copy_act = 1'b1; rst = 1'b1;
    tick();
    chk("R1 reset imm", 16'(imm_bits), 16'h0);
    chk("R1 reset bank", 16'(bank_we), 16'h0);
    rst = 1'b0; copy_act = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule